// File: doc/BRIEF.md
# Thermal Throttle PWM Override

This block produces two active-high throttle requests, one per processor. An 8-bit control word is loaded through a simple write strobe. It holds a shared duty-cycle code, a mask bit for each channel's regulator-hot input, and a force bit for each channel. When a channel is forced, its request is a pulse train with a period of 80 throttle ticks. Each period begins with an asserted stretch of (code+1)×5 ticks. When a channel's regulator-hot input is active and not masked, the request is held high continuously. A tie input makes both requests equal to the OR of the two channels.

The slow throttle clock is modelled as a one-cycle `tick` enable on the system clock. A single period counter serves both channels. A two-state phase machine tracks whether the current tick lies in the asserted part of the period. The machine has two states. `PH_ASSERT` leaves for `PH_RELEASE` on the tick on which the count reaches the asserted length. Both states return to `PH_ASSERT` on the tick that wraps the count from 79 to 0. On that same tick, a newly written duty code is taken into use, so a period is never cut short or lengthened partway through.

Top module: `thr_throttle_pwm`

## Requirements
- R1: After synchronous reset, the control word is 00h, the period count is 0, the latched duty code is 0 and both `throttle` outputs are low.
- R2: A cycle with `wr_en` high loads `wr_data` into the control word. The field layout is: bits 3:0 hold the duty code; bit 4 masks the hot input of channel 0 and bit 5 masks the hot input of channel 1; bit 6 forces channel 0 and bit 7 forces channel 1.
- R3: The period count steps only on cycles with `tick` high. It runs 0 to 79 and then wraps, so one period is 80 ticks.
- R4: A forced channel is high during the first (code+1)×5 ticks of each period and low for the rest. Code 0 gives 5 ticks; code Fh gives 80 ticks, which is continuous assertion.
- R5: A channel whose force bit is clear and whose unmasked hot term is inactive is low, provided tie mode does not carry the other channel onto it.
- R6: An active `vr_hot` bit whose mask bit is clear holds that channel high continuously. An active `vr_hot` bit whose mask bit is set has no effect on that channel.
- R7: With `tie_en` high, both outputs equal the OR of the two channels' request terms, even if only one force bit is set.
- R8: A new duty code written partway through a period is first used in the period that starts at the next wrap.
- R9: Outputs are registered. Each output reflects the control word, the inputs and the phase as they stood in the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle enable standing for the throttle clock |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word value to load |
| vr_hot | input | 2 | Regulator-hot inputs, one per channel, active high |
| tie_en | input | 1 | Tie both channels together |
| throttle | output | 2 | Throttle request outputs, active high |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `tick` is a one-cycle strobe and is not held in a way the phase machine cannot follow. In particular, the check that the hot input forces an output high one cycle later relies on the mask bit and the hot input both being sampled at the same edge. The stimulus changes every input only at the falling clock edge. It generates `tick` from a counter, either on every cycle or on every third cycle. It writes the control word during both halves of a period, so that the deferred duty update is exercised.

// File: rtl/thr_pkg.sv
package thr_pkg;
    // phase of the shared throttle period
    typedef enum logic {
        PH_ASSERT  = 1'b0,
        PH_RELEASE = 1'b1
    } phase_t;
endpackage

// File: rtl/thr_ctrl_reg.sv
module thr_ctrl_reg #(
    parameter int DC_W = 4,
    parameter int CH   = 2,
    localparam int REG_W = DC_W + 2 * CH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [DC_W-1:0]  duty_code,
    output logic [CH-1:0]    hot_mask,
    output logic [CH-1:0]    force_on
);
    logic [REG_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_data;
    end

    assign duty_code = ctrl_q[DC_W-1:0];
    assign hot_mask  = ctrl_q[DC_W +: CH];
    assign force_on  = ctrl_q[DC_W+CH +: CH];

    // R2: a write lands in the word on the next edge
    a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ({force_on, hot_mask, duty_code} == $past(wr_data)));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({force_on, hot_mask, duty_code}));
endmodule

// File: rtl/thr_period_fsm.sv
module thr_period_fsm
    import thr_pkg::*;
#(
    parameter int PERIOD = 80,
    parameter int STEP   = 5,
    parameter int DC_W   = 4,
    localparam int CNT_W = $clog2(PERIOD),
    localparam int TH_W  = CNT_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [DC_W-1:0] duty_code,
    output logic            pwm_on
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [DC_W-1:0]  dc_lat_q;
    logic [TH_W-1:0]  thresh;
    logic             wrap;
    phase_t           phase_q, phase_d;

    assign cnt_inc = cnt_q + CNT_W'(1);
    assign wrap    = (cnt_q == CNT_W'(PERIOD - 1));
    assign thresh  = TH_W'((int'(dc_lat_q) + 1) * STEP);

    // counter and duty latch
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            dc_lat_q <= '0;
        end else if (tick) begin
            if (wrap) begin
                cnt_q    <= '0;
                dc_lat_q <= duty_code;
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PH_ASSERT;
        else
            phase_q <= phase_d;
    end

    // next state
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_ASSERT: begin
                if (tick && !wrap && (TH_W'(cnt_inc) == thresh))
                    phase_d = PH_RELEASE;
            end
            PH_RELEASE: begin
                if (tick && wrap)
                    phase_d = PH_ASSERT;
            end
            default: phase_d = PH_ASSERT;
        endcase
    end

    // outputs
    always_comb begin
        pwm_on = (phase_q == PH_ASSERT);
    end

    a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(PERIOD));
    a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));
    a_r4_phase_matches_count: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ASSERT) == (TH_W'(cnt_q) < thresh));
    a_r8_duty_held_in_period: assert property (@(posedge clk) disable iff (rst)
        !(tick && wrap) |=> $stable(dc_lat_q));
endmodule

// File: rtl/thr_out_merge.sv
module thr_out_merge #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwm_on,
    input  logic          tie_en,
    input  logic [CH-1:0] force_on,
    input  logic [CH-1:0] hot_mask,
    input  logic [CH-1:0] vr_hot,
    output logic [CH-1:0] out_q
);
    logic [CH-1:0] req;
    logic [CH-1:0] out_d;

    for (genvar g = 0; g < CH; g++) begin : g_req
        assign req[g] = (force_on[g] & pwm_on) | (vr_hot[g] & ~hot_mask[g]);

        a_r6_hot_asserts: assert property (@(posedge clk) disable iff (rst)
            (vr_hot[g] && !hot_mask[g]) |=> out_q[g]);
    end

    always_comb begin
        if (tie_en)
            out_d = {CH{|req}};
        else
            out_d = req;
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    a_r7_tie_equal: assert property (@(posedge clk) disable iff (rst)
        tie_en |=> (out_q == '0 || out_q == '1));
    a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
        (force_on == '0 && (vr_hot & ~hot_mask) == '0) |=> out_q == '0);
endmodule

// File: rtl/thr_throttle_pwm.sv
module thr_throttle_pwm #(
    parameter int PERIOD = 80,
    parameter int STEP   = 5,
    parameter int DC_W   = 4,
    parameter int CH     = 2,
    localparam int REG_W = DC_W + 2 * CH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [CH-1:0]    vr_hot,
    input  logic             tie_en,
    output logic [CH-1:0]    throttle
);
    logic [DC_W-1:0] duty_code;
    logic [CH-1:0]   hot_mask;
    logic [CH-1:0]   force_on;
    logic            pwm_on;

    thr_ctrl_reg #(.DC_W(DC_W), .CH(CH)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .duty_code (duty_code),
        .hot_mask  (hot_mask),
        .force_on  (force_on)
    );

    thr_period_fsm #(.PERIOD(PERIOD), .STEP(STEP), .DC_W(DC_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .duty_code (duty_code),
        .pwm_on    (pwm_on)
    );

    thr_out_merge #(.CH(CH)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .pwm_on   (pwm_on),
        .tie_en   (tie_en),
        .force_on (force_on),
        .hot_mask (hot_mask),
        .vr_hot   (vr_hot),
        .out_q    (throttle)
    );

    // R1: outputs are low on the edge after reset
    a_r1_reset_low: assert property (@(posedge clk)
        $past(rst) |-> throttle == '0);
endmodule

// File: tb/test_thr_throttle_pwm.sv
module test_thr_throttle_pwm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] vr_hot = 2'b00;
    logic       tie_en = 1'b0;
    logic [1:0] throttle;

    int    n_checks = 0;
    int    n_fail = 0;
    int    tick_div = 1;
    int    tick_ctr = 0;
    string req_tag = "R1";

    // reference model state
    int         m_cnt = 0;
    int         m_dc = 0;
    logic [7:0] m_reg = 8'h00;
    logic [1:0] m_exp = 2'b00;
    bit         m_valid = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    thr_throttle_pwm i_thr_throttle_pwm (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .vr_hot   (vr_hot),
        .tie_en   (tie_en),
        .throttle (throttle)
    );

    // behavioural reference, evaluated at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_dc = 0; m_reg = 8'h00; m_exp = 2'b00;
            m_valid = 1'b1;
        end else begin
            bit       on;
            bit [1:0] t;
            on = (m_cnt < (m_dc + 1) * 5);
            for (int c = 0; c < 2; c++)
                t[c] = (m_reg[6+c] && on) || (vr_hot[c] && !m_reg[4+c]);
            m_exp = tie_en ? {2{|t}} : t;
            if (tick) begin
                if (m_cnt == 79) begin
                    m_cnt = 0;
                    m_dc = int'(m_reg[3:0]);
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (wr_en) m_reg = wr_data;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (m_valid) begin
            n_checks++;
            if (throttle !== m_exp) begin
                n_fail++;
                $display("FAIL %s: throttle=%b expected=%b (cnt=%0d)",
                         req_tag, throttle, m_exp, m_cnt);
            end
        end
    end

    // tick generator
    always @(negedge clk) begin
        if (tick_ctr + 1 >= tick_div) begin
            tick_ctr <= 0;
            tick <= 1'b1;
        end else begin
            tick_ctr <= tick_ctr + 1;
            tick <= 1'b0;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        req_tag = "R1";
        run(3);
        rst = 1'b0;
        n_checks++;
        if (throttle !== 2'b00) begin
            n_fail++;
            $display("FAIL R1: throttle=%b expected=00", throttle);
        end
        // R5: nothing requested
        req_tag = "R5";
        run(20);
        // R2 / R4: force ch0 code 0, ch1 code 3, both code F
        req_tag = "R4";
        write_ctrl(8'h40);
        run(200);
        req_tag = "R2";
        write_ctrl(8'h83);
        run(200);
        req_tag = "R4";
        write_ctrl(8'hCF);
        run(120);
        // R3: slower ticks, counter holds between them
        req_tag = "R3";
        tick_div = 3;
        write_ctrl(8'h45);
        run(500);
        tick_div = 1;
        // R8: change duty partway through a period
        req_tag = "R8";
        write_ctrl(8'h42);
        run(100);
        write_ctrl(8'h4A);
        run(200);
        write_ctrl(8'h41);
        run(10);
        write_ctrl(8'h4D);
        run(200);
        // R6: hot inputs, masked and unmasked
        req_tag = "R6";
        write_ctrl(8'h00);
        vr_hot = 2'b11;
        run(50);
        write_ctrl(8'h10);
        run(50);
        write_ctrl(8'h30);
        run(50);
        vr_hot = 2'b00;
        run(10);
        // R7: tie mode
        req_tag = "R7";
        tie_en = 1'b1;
        write_ctrl(8'h40);
        run(200);
        write_ctrl(8'h20);
        vr_hot = 2'b10;
        run(30);
        vr_hot = 2'b01;
        run(30);
        // R9: single-cycle hot pulses show one cycle later
        req_tag = "R9";
        tie_en = 1'b0;
        write_ctrl(8'h00);
        for (int k = 0; k < 6; k++) begin
            vr_hot = 2'(k);
            run(1);
            vr_hot = 2'b00;
            run(2);
        end
        // R1: reset mid-run
        req_tag = "R1";
        write_ctrl(8'hCF);
        run(5);
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        run(20);
        summary();
        $finish;
    end
endmodule